// File: doc/BRIEF.md
# Instruction Queue with Multi-Unit Dispatch

This block is an eight-slot, in-order buffer of 32-bit instruction words placed between an instruction fetch path and three execution units: integer, branch and floating-point. A fetch source delivers a batch of up to eight words in one cycle. The words land in the lowest free slots, and the queue asks for more whenever it has room and no request is already waiting. Each word receives a small class tag as it enters, taken from its two top bits.

The branch unit and the floating-point unit may each take the oldest matching word from anywhere in the four bottom slots, but only while that unit's decode stage is free. The integer unit takes words only from slot 0, which acts as its decode stage. Words that leave from the middle of the queue close up their gaps, and the remaining words keep their program order. A flush empties every slot at once, for example after a mispredicted branch, so that a new batch can be fetched.

Top module: `instr_queue`

## Requirements
- R1: After a synchronous active-low reset, all slots are empty, `int_valid`, `br_valid` and `fp_valid` are low and `fetch_req` is high.
- R2: `fetch_req` is high exactly when slot 7 is empty and no request is pending. A request becomes pending in a cycle where `fetch_req` is high and neither `fill_valid` nor `flush` is high. An accepted fill or a flush clears the pending request.
- R3: When `fill_valid` is high, lanes 0 to `fill_count`-1 of `fill_words` (lane k at bits k*32+31 down to k*32, lane 0 oldest) enter the lowest slots that are free after this cycle's removals, in lane order. Lanes that do not fit are dropped.
- R4: The class tag comes from word bits 31:30: 2'b10 is branch, 2'b11 is floating-point, and 2'b00 and 2'b01 are integer.
- R5: `int_valid` is high exactly when slot 0 holds an integer word, and `int_word` is then that word. Integer words never leave from any other slot.
- R6: `br_valid` is high exactly when one of slots 0 to 3 holds a branch word, and `br_word` is the lowest such word. A branch word in slot 4 or above is not offered.
- R7: `fp_valid` and `fp_word` follow the same rule as R6, for floating-point words.
- R8: An offered word leaves the queue at a clock edge where its unit's ready input is high. Otherwise it stays offered with the same word. At most one word goes to each unit per cycle.
- R9: After removals, the remaining words move down with no gaps and keep their relative order.
- R10: A flush takes priority over dispatch and fill. In the next cycle every slot is empty, no unit is offered a word, and `fetch_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empty the queue and drop the pending request |
| fetch_req | output | 1 | Request a new batch of words |
| fill_valid | input | 1 | A fetched batch is present |
| fill_count | input | 4 | Number of valid lanes in the batch (0 to 8) |
| fill_words | input | 256 | Eight 32-bit lanes, lane 0 oldest |
| int_valid | output | 1 | Slot 0 holds an integer word |
| int_word | output | 32 | Word offered to the integer unit |
| int_ready | input | 1 | Integer decode stage is free |
| br_valid | output | 1 | A branch word is offered |
| br_word | output | 32 | Word offered to the branch unit |
| br_ready | input | 1 | Branch decode stage is free |
| fp_valid | output | 1 | A floating-point word is offered |
| fp_word | output | 32 | Word offered to the floating-point unit |
| fp_ready | input | 1 | Floating-point decode stage is free |

## Verification
All outputs are decoded from the slot registers. A wrong slot state therefore shows on the dispatch ports in the very next cycle, as a word from the wrong class or with the wrong value, or as a valid flag that should not be there. A slip in compaction order, or a lane that is taken or dropped in error, does not show at once. It shows later, when the disturbed word reaches slot 0 or the four-slot window and the word sequence seen by one of the units no longer matches the program order. A stuck pending flag shows on `fetch_req` one cycle after a fill or a flush.

// File: rtl/iq_pkg.sv
// Shared types for the instruction queue: the instruction width, the class
// tag and the slot record. Assumes every instruction word is the same width.
package iq_pkg;
    localparam int IW = 32;

    typedef enum logic [1:0] {
        CLS_INT = 2'd0,
        CLS_BR  = 2'd1,
        CLS_FP  = 2'd2
    } iclass_e;

    typedef struct packed {
        logic          valid;
        iclass_e       cls;
        logic [IW-1:0] word;
    } slot_t;
endpackage

// File: rtl/iq_class_dec.sv
// Class tag decoder: maps the two top bits of an instruction word onto the
// unit that executes it. Assumes the caller passes bits 31:30 only.
module iq_class_dec
    import iq_pkg::*;
(
    input  logic [1:0] opc,
    output iclass_e    cls
);
    // Top bits 10 select branch, 11 select floating point, the rest integer.
    always_comb begin
        case (opc)
            2'b10:   cls = CLS_BR;
            2'b11:   cls = CLS_FP;
            default: cls = CLS_INT;
        endcase
    end
endmodule

// File: rtl/iq_pick.sv
// Lowest-index picker: reports whether any request bit is set and the index
// of the lowest one. Assumes WIN is at least 1.
module iq_pick #(
    parameter  int WIN = 4,
    localparam int XW  = (WIN > 1) ? $clog2(WIN) : 1
) (
    input  logic [WIN-1:0] hit,
    output logic           found,
    output logic [XW-1:0]  idx
);
    // Scan from the top down so that the lowest set bit wins.
    always_comb begin
        found = |hit;
        idx   = '0;
        for (int i = WIN - 1; i >= 0; i--) begin
            if (hit[i]) idx = XW'(i);
        end
    end
endmodule

// File: rtl/iq_compact.sv
// Next-state builder: closes the gaps left by removed slots while keeping
// their order, then appends fresh words in lane order into the lowest free
// slots. Assumes the current valid slots are contiguous from slot 0.
module iq_compact
    import iq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input  slot_t            cur   [DEPTH],
    input  logic [DEPTH-1:0] drop,
    input  logic             fill_en,
    input  logic [CW-1:0]    fill_count,
    input  slot_t            fresh [DEPTH],
    output slot_t            nxt   [DEPTH]
);
    // Move the survivors down in order, then add as many fresh lanes as fit.
    always_comb begin
        int kept;
        int nfill;
        nxt   = '{default: '0};
        kept  = 0;
        for (int j = 0; j < DEPTH; j++) begin
            if (cur[j].valid && !drop[j]) begin
                nxt[kept] = cur[j];
                kept++;
            end
        end
        nfill = fill_en ? int'(fill_count) : 0;
        for (int k = 0; k < DEPTH; k++) begin
            if (k < nfill && kept + k < DEPTH) nxt[kept + k] = fresh[k];
        end
    end
endmodule

// File: rtl/instr_queue.sv
// Instruction queue with dispatch to three units. Slot 0 is the integer
// decode stage. The branch and floating-point units each take their lowest
// matching word from slots 0..WIN-1. Assumes WIN <= DEPTH and that a fill
// batch has at most DEPTH lanes.
module instr_queue
    import iq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIN   = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    output logic                        fetch_req,
    input  logic                        fill_valid,
    input  logic [$clog2(DEPTH+1)-1:0]  fill_count,
    input  logic [DEPTH*IW-1:0]         fill_words,
    output logic                        int_valid,
    output logic [IW-1:0]               int_word,
    input  logic                        int_ready,
    output logic                        br_valid,
    output logic [IW-1:0]               br_word,
    input  logic                        br_ready,
    output logic                        fp_valid,
    output logic [IW-1:0]               fp_word,
    input  logic                        fp_ready
);
    localparam int CW  = $clog2(DEPTH + 1);
    localparam int XW  = (WIN > 1) ? $clog2(WIN) : 1;
    localparam int NU  = 2;

    slot_t            q     [DEPTH];
    slot_t            nxt   [DEPTH];
    slot_t            fresh [DEPTH];
    logic             pend;
    logic [DEPTH-1:0] drop;
    logic [WIN-1:0]   hit_u   [NU];
    logic             found_u [NU];
    logic [XW-1:0]    idx_u   [NU];
    logic             ready_u [NU];
    logic [IW-1:0]    word_u  [NU];
    iclass_e          want_u  [NU];

    // Tag every fill lane with its class as it enters.
    for (genvar k = 0; k < DEPTH; k++) begin : g_dec
        iclass_e lane_cls;
        iq_class_dec u_dec (
            .opc (fill_words[k*IW + IW - 2 +: 2]),
            .cls (lane_cls)
        );
        assign fresh[k] = '{valid: 1'b1, cls: lane_cls, word: fill_words[k*IW +: IW]};
    end

    assign want_u[0]  = CLS_BR;
    assign want_u[1]  = CLS_FP;
    assign ready_u[0] = br_ready;
    assign ready_u[1] = fp_ready;

    // Find the slots in the low window that hold words for each windowed unit.
    always_comb begin
        for (int u = 0; u < NU; u++) begin
            for (int s = 0; s < WIN; s++) begin
                hit_u[u][s] = q[s].valid && (q[s].cls == want_u[u]);
            end
        end
    end

    // One lowest-slot picker per windowed unit.
    for (genvar u = 0; u < NU; u++) begin : g_unit
        iq_pick #(.WIN(WIN)) u_pick (
            .hit   (hit_u[u]),
            .found (found_u[u]),
            .idx   (idx_u[u])
        );
        assign word_u[u] = q[idx_u[u]].word;
    end

    assign int_valid = q[0].valid && (q[0].cls == CLS_INT);
    assign int_word  = q[0].word;
    assign br_valid  = found_u[0];
    assign br_word   = word_u[0];
    assign fp_valid  = found_u[1];
    assign fp_word   = word_u[1];
    assign fetch_req = !q[DEPTH-1].valid && !pend;

    // Mark the slots that leave this cycle, at most one for each unit.
    always_comb begin
        drop = '0;
        if (int_valid && int_ready) drop[0] = 1'b1;
        for (int u = 0; u < NU; u++) begin
            if (found_u[u] && ready_u[u]) drop[int'(idx_u[u])] = 1'b1;
        end
    end

    iq_compact #(.DEPTH(DEPTH), .CW(CW)) u_compact (
        .cur        (q),
        .drop       (drop),
        .fill_en    (fill_valid),
        .fill_count (fill_count),
        .fresh      (fresh),
        .nxt        (nxt)
    );

    // Slot and request state: reset and flush clear it, otherwise take the next state.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            q    <= '{default: '0};
            pend <= 1'b0;
        end else begin
            q    <= nxt;
            pend <= fill_valid ? 1'b0 : (fetch_req ? 1'b1 : pend);
        end
    end
endmodule

// File: rtl/iq_checker.sv
// Port-level properties of the instruction queue, bound into every instance.
module iq_checker
    import iq_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          flush,
    input logic          fill_valid,
    input logic          fetch_req,
    input logic          int_valid,
    input logic [IW-1:0] int_word,
    input logic          int_ready,
    input logic          br_valid,
    input logic [IW-1:0] br_word,
    input logic          br_ready,
    input logic          fp_valid,
    input logic [IW-1:0] fp_word,
    input logic          fp_ready
);
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!int_valid && !br_valid && !fp_valid && fetch_req));

    a_r2_single_request: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fill_valid && !flush) |=> !fetch_req);

    a_r5_int_class: assert property (@(posedge clk) disable iff (!rst_n)
        int_valid |-> !int_word[IW-1]);

    a_r6_br_class: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |-> (br_word[IW-1:IW-2] == 2'b10));

    a_r7_fp_class: assert property (@(posedge clk) disable iff (!rst_n)
        fp_valid |-> (fp_word[IW-1:IW-2] == 2'b11));

    a_r8_int_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (int_valid && !int_ready && !flush) |=> (int_valid && $stable(int_word)));

    a_r8_br_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !br_ready && !flush) |=> (br_valid && $stable(br_word)));

    a_r8_fp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_valid && !fp_ready && !flush) |=> (fp_valid && $stable(fp_word)));

    a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!int_valid && !br_valid && !fp_valid && fetch_req));
endmodule

bind instr_queue iq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .fill_valid (fill_valid),
    .fetch_req  (fetch_req),
    .int_valid  (int_valid),
    .int_word   (int_word),
    .int_ready  (int_ready),
    .br_valid   (br_valid),
    .br_word    (br_word),
    .br_ready   (br_ready),
    .fp_valid   (fp_valid),
    .fp_word    (fp_word),
    .fp_ready   (fp_ready)
);

// File: tb/sim_instr_queue.sv
// Self-checking bench: directed corner cases, then seeded random traffic,
// compared each cycle against a queue model kept in bench functions.
module sim_instr_queue;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          fetch_req;
    logic          fill_valid = 1'b0;
    logic [3:0]    fill_count = '0;
    logic [N*32-1:0] fill_words = '0;
    logic          int_valid, br_valid, fp_valid;
    logic [31:0]   int_word, br_word, fp_word;
    logic          int_ready = 1'b0, br_ready = 1'b0, fp_ready = 1'b0;

    int nchk  = 0;
    int nfail = 0;

    logic [31:0] mq [N];
    int          mn    = 0;
    bit          mpend = 1'b0;

    logic [31:0] gw [N];
    bit g_fl, g_fv, g_ir, g_br, g_fr;
    int g_fc;

    always #(CLK_PERIOD/2) clk = ~clk;

    instr_queue u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_req(fetch_req),
        .fill_valid(fill_valid), .fill_count(fill_count), .fill_words(fill_words),
        .int_valid(int_valid), .int_word(int_word), .int_ready(int_ready),
        .br_valid(br_valid), .br_word(br_word), .br_ready(br_ready),
        .fp_valid(fp_valid), .fp_word(fp_word), .fp_ready(fp_ready)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R4: class of a word, 0 integer, 1 branch, 2 floating point.
    function automatic int cls_of(input logic [31:0] w);
        if (w[31:30] == 2'b10) return 1;
        if (w[31:30] == 2'b11) return 2;
        return 0;
    endfunction

    // Lowest model slot among 0..3 holding class c, or -1.
    function automatic int pick(input int c);
        for (int j = 0; j < 4; j++) begin
            if (j < mn && cls_of(mq[j]) == c) return j;
        end
        return -1;
    endfunction

    // Compare the ports with the model, apply the inputs, advance one cycle.
    task automatic step();
        int ib, ifp;
        bit iv, er;
        logic [31:0] t [N];
        int nk;
        ib  = pick(1);
        ifp = pick(2);
        iv  = (mn > 0) && (cls_of(mq[0]) == 0);
        er  = (mn < N) && !mpend;
        chk("R2 fetch_req", 32'(fetch_req), 32'(er));
        chk("R5 int_valid", 32'(int_valid), 32'(iv));
        if (iv) chk("R5/R9 int_word order", int_word, mq[0]);
        chk("R6 br_valid", 32'(br_valid), 32'(ib >= 0));
        if (ib >= 0) chk("R6/R9 br_word", br_word, mq[ib]);
        chk("R7 fp_valid", 32'(fp_valid), 32'(ifp >= 0));
        if (ifp >= 0) chk("R7/R9 fp_word", fp_word, mq[ifp]);
        flush      = g_fl;
        fill_valid = g_fv;
        fill_count = 4'(g_fc);
        for (int k = 0; k < N; k++) fill_words[k*32 +: 32] = gw[k];
        int_ready = g_ir;
        br_ready  = g_br;
        fp_ready  = g_fr;
        if (g_fl) begin
            mn = 0;
            mpend = 1'b0;
        end else begin
            nk = 0;
            for (int j = 0; j < mn; j++) begin
                if (!((j == 0 && iv && g_ir) || (j == ib && g_br) || (j == ifp && g_fr))) begin
                    t[nk] = mq[j];
                    nk++;
                end
            end
            if (g_fv) begin
                for (int k = 0; k < g_fc; k++) begin
                    if (nk < N) begin
                        t[nk] = gw[k];
                        nk++;
                    end
                end
            end
            for (int j = 0; j < nk; j++) mq[j] = t[j];
            mn = nk;
            mpend = g_fv ? 1'b0 : (er ? 1'b1 : mpend);
        end
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic idle();
        g_fl = 0; g_fv = 0; g_fc = 0; g_ir = 0; g_br = 0; g_fr = 0;
        for (int k = 0; k < N; k++) gw[k] = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", nchk, 0);
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 int_valid", 32'(int_valid), 32'd0);
        chk("R1 br_valid", 32'(br_valid), 32'd0);
        chk("R1 fp_valid", 32'(fp_valid), 32'd0);
        chk("R1 fetch_req", 32'(fetch_req), 32'd1);

        // R3/R4: three words of different classes land in slots 0..2
        idle(); g_fv = 1; g_fc = 3;
        gw[0] = 32'h0000_0011; gw[1] = 32'h8000_0022; gw[2] = 32'hC000_0033;
        step();
        chk("R3 int_word slot0", int_word, 32'h0000_0011);
        chk("R4 br class", br_word, 32'h8000_0022);
        chk("R4 fp class", fp_word, 32'hC000_0033);
        chk("R2 req after fill", 32'(fetch_req), 32'd1);

        // R8: stall holds every offer; R2: request now pending
        idle(); step();
        chk("R8 int hold", int_word, 32'h0000_0011);
        chk("R8 br hold", 32'(br_valid), 32'd1);
        chk("R2 pending blocks req", 32'(fetch_req), 32'd0);

        // R9: branch leaves from slot 1, the fp word closes the gap
        idle(); g_br = 1; step();
        chk("R8 br removed", 32'(br_valid), 32'd0);
        chk("R9 fp after compaction", fp_word, 32'hC000_0033);
        chk("R9 int stays", int_word, 32'h0000_0011);

        // R10: flush beats fill and dispatch
        idle(); g_fl = 1; g_fv = 1; g_fc = 2; g_ir = 1; g_br = 1; g_fr = 1;
        gw[0] = 32'h0000_0055; gw[1] = 32'h8000_0066;
        step();
        chk("R10 int empty", 32'(int_valid), 32'd0);
        chk("R10 fp empty", 32'(fp_valid), 32'd0);
        chk("R10 req", 32'(fetch_req), 32'd1);

        // R6/R7: branch in slot 4 and fp in slot 5 are out of the window
        idle(); g_fv = 1; g_fc = 8;
        for (int k = 0; k < N; k++) gw[k] = 32'h0000_0100 + 32'(k);
        gw[4] = 32'h8000_0104; gw[5] = 32'hC000_0105;
        step();
        chk("R6 br beyond window", 32'(br_valid), 32'd0);
        chk("R7 fp beyond window", 32'(fp_valid), 32'd0);
        chk("R2 full no req", 32'(fetch_req), 32'd0);

        // R3: full queue, one slot frees, only lane 0 of three is kept
        idle(); g_fv = 1; g_fc = 3; g_ir = 1;
        gw[0] = 32'h0000_0200; gw[1] = 32'h0000_0201; gw[2] = 32'h0000_0202;
        step();
        chk("R6 br at slot 3", br_word, 32'h8000_0104);
        chk("R5 int next", int_word, 32'h0000_0101);

        idle(); g_ir = 1; g_br = 1; g_fr = 1;
        repeat (5) step();
        chk("R3 last kept lane", int_word, 32'h0000_0200);
        step();
        chk("R3 excess lanes dropped", 32'(int_valid), 32'd0);

        // Seeded random traffic
        for (int c = 0; c < 4000; c++) begin
            idle();
            g_ir = ($urandom_range(0, 1) == 1);
            g_br = ($urandom_range(0, 1) == 1);
            g_fr = ($urandom_range(0, 2) != 0);
            g_fl = ($urandom_range(0, 39) == 0);
            if (mpend && $urandom_range(0, 4) < 2) begin
                g_fv = 1;
                g_fc = $urandom_range(0, 8);
                for (int k = 0; k < N; k++) gw[k] = $urandom;
            end
            step();
        end

        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule